// File: doc/BRIEF.md
# Synthesizer Register Load Sequencer

This block turns a tuning request into the ordered register writes that a fractional-N frequency synthesizer needs. It is given an integer divide value, a 25-bit fraction and the reference and function settings. It builds each 32-bit register word and offers it on a valid/ready write port. The bits at [2:0] of each word carry the 3-bit register address. A separate serializer, outside this block, takes each accepted word and puts it on the wire.

A `start` pulse runs the full power-up load of five registers, in the order test (address 4), function (3), reference divider (2), fraction-low (1) and main integer/fraction (0). A `retune` pulse writes only the fraction-low register and then the main register, because the synthesizer applies a new fraction when the main register is written. The fraction is split into a 12-bit upper part and a 13-bit lower part. The upper part goes into the main register beside the integer N. The lower part goes into the fraction-low register, so the fraction equals upper × 2^13 + lower and the output frequency is (N + fraction/2^25) times the comparison frequency.

The settings are held in registers from the cycle a request is accepted, so the inputs may change while a load is running. `busy` is high for the whole load. `done` pulses for one cycle when the main register word is accepted.

Top module: `synth_load_seq`

## Requirements
- R1: After reset, `busy`, `wr_valid` and `done` are 0.
- R2: A `start` pulse while idle produces exactly five writes with addresses 4, 3, 2, 1, 0 in that order, each address in bits [2:0] of `wr_data`.
- R3: A `retune` pulse while idle produces exactly two writes: address 1, then address 0, with the newly captured N and fraction.
- R4: While `wr_valid` is high and `wr_ready` is low, `wr_valid` stays high and `wr_data` holds its value; the next register is offered only after a cycle with both high.
- R5: Main word (address 0): N at [30:15], the upper 12 fraction bits (fraction[24:13]) at [14:3], bit 31 zero.
- R6: Fraction-low word (address 1): fraction[12:0] at [15:3], bits [31:16] zero.
- R7: Reference word (address 2): divider at [7:3], halving at bit 8, doubling at bit 9, and cycle-slip-reduction enable at bit 28. Bit 28 is set only when both `csr_en` and `pd_pos` are 1. All other bits are zero.
- R8: Function word (address 3): `func_misc` at [31:7], detector polarity `pd_pos` at bit 6, [5:3] zero. Test word (address 4): `test_val` at [31:3].
- R9: `start` and `retune` pulses that arrive while `busy` is high are ignored. Input changes while `busy` is high do not alter the words of the running load.
- R10: `done` is high for exactly one cycle, in the cycle after the address-0 word is accepted, and `busy` falls in that same cycle.
- R11: If `start` and `retune` are both high while idle, the full five-register load runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request full power-up load |
| retune | input | 1 | Request fraction-only update |
| n_int | input | 16 | Integer divide value N |
| frac | input | 25 | Fraction word |
| r_div | input | 5 | Reference divider value |
| ref_half | input | 1 | Reference divide-by-2 select |
| ref_dbl | input | 1 | Reference doubler select |
| csr_en | input | 1 | Cycle-slip-reduction request |
| pd_pos | input | 1 | Phase detector polarity, 1 = positive |
| func_misc | input | 25 | Remaining function register bits |
| test_val | input | 29 | Test register payload |
| wr_valid | output | 1 | Register word offered |
| wr_ready | input | 1 | Serializer accepts the word |
| wr_data | output | 32 | Register word with address in [2:0] |
| busy | output | 1 | Load sequence in progress |
| done | output | 1 | One-cycle pulse at end of load |

## Verification
The bench builds the block with its default widths: a 16-bit N and a fraction split 12/13. With these widths the specified example (N = 580, upper 81, lower 7537) can be applied directly, and every field of every word has a fixed bit position that the bench restates with its own arithmetic. The write port is driven by a pseudo-random ready pattern, so holding a stalled word and advancing only on a handshake are both exercised. Further cases cover a request during a running load, the polarity gate on bit 28, and simultaneous start and retune.

// File: rtl/synth_seq_pkg.sv
package synth_seq_pkg;
  localparam int ADDR_W   = 3;
  localparam int WORD_W   = 32;
  localparam int CSR_BIT  = 28;
  localparam int POL_BIT  = 6;

  localparam logic [ADDR_W-1:0] SEL_MAIN = 3'd0;
  localparam logic [ADDR_W-1:0] SEL_FLO  = 3'd1;
  localparam logic [ADDR_W-1:0] SEL_REF  = 3'd2;
  localparam logic [ADDR_W-1:0] SEL_FUNC = 3'd3;
  localparam logic [ADDR_W-1:0] SEL_TEST = 3'd4;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import synth_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              retune,
  input  logic              fire,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] step,
  output logic              go_full,
  output logic              go_frac,
  output logic              accept_last
);
  logic              busy_q;
  logic              done_q;
  logic [ADDR_W-1:0] step_q;

  assign go_full     = start && !busy_q;
  assign go_frac     = retune && !start && !busy_q;
  assign accept_last = fire && busy_q && (step_q == SEL_MAIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= SEL_MAIN;
    end else begin
      done_q <= 1'b0;
      if (go_full) begin
        busy_q <= 1'b1;
        step_q <= SEL_TEST;
      end else if (go_frac) begin
        busy_q <= 1'b1;
        step_q <= SEL_FLO;
      end else if (fire && busy_q) begin
        if (step_q == SEL_MAIN) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q - 3'd1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign step = step_q;

  // R4
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !fire |=> busy_q && $stable(step_q));
  // R2
  step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && busy_q && step_q != SEL_MAIN |=> step_q == $past(step_q) - 3'd1);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R10
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(accept_last) && !busy_q);
  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (start || retune) && !fire |=> busy_q && $stable(step_q));
endmodule

// File: rtl/cfg_hold.sv
module cfg_hold #(
  parameter int N_W    = 16,
  parameter int FRAC_W = 25,
  parameter int RDIV_W = 5,
  parameter int MISC_W = 25,
  parameter int TEST_W = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_all,
  input  logic              cap_frac,
  input  logic [N_W-1:0]    n_in,
  input  logic [FRAC_W-1:0] frac_in,
  input  logic [RDIV_W-1:0] rdiv_in,
  input  logic              half_in,
  input  logic              dbl_in,
  input  logic              csr_in,
  input  logic              pol_in,
  input  logic [MISC_W-1:0] misc_in,
  input  logic [TEST_W-1:0] test_in,
  output logic [N_W-1:0]    n_q,
  output logic [FRAC_W-1:0] frac_q,
  output logic [RDIV_W-1:0] rdiv_q,
  output logic              half_q,
  output logic              dbl_q,
  output logic              csr_q,
  output logic              pol_q,
  output logic [MISC_W-1:0] misc_q,
  output logic [TEST_W-1:0] test_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q    <= '0;
      frac_q <= '0;
    end else if (cap_all || cap_frac) begin
      n_q    <= n_in;
      frac_q <= frac_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdiv_q <= '0;
      half_q <= 1'b0;
      dbl_q  <= 1'b0;
      csr_q  <= 1'b0;
      pol_q  <= 1'b0;
      misc_q <= '0;
      test_q <= '0;
    end else if (cap_all) begin
      rdiv_q <= rdiv_in;
      half_q <= half_in;
      dbl_q  <= dbl_in;
      csr_q  <= csr_in;
      pol_q  <= pol_in;
      misc_q <= misc_in;
      test_q <= test_in;
    end
  end

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_all && !cap_frac |=> $stable(n_q) && $stable(frac_q) && $stable(misc_q));
  // R3
  retune_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_frac && !cap_all |=> $stable(rdiv_q) && $stable(pol_q) && $stable(test_q));
endmodule

// File: rtl/word_mux.sv
module word_mux
  import synth_seq_pkg::*;
#(
  parameter int N_W    = 16,
  parameter int FMSB_W = 12,
  parameter int FLSB_W = 13,
  parameter int RDIV_W = 5,
  localparam int FRAC_W = FMSB_W + FLSB_W,
  localparam int MISC_W = WORD_W - POL_BIT - 1,
  localparam int TEST_W = WORD_W - ADDR_W
) (
  input  logic [ADDR_W-1:0] step,
  input  logic [N_W-1:0]    n_q,
  input  logic [FRAC_W-1:0] frac_q,
  input  logic [RDIV_W-1:0] rdiv_q,
  input  logic              half_q,
  input  logic              dbl_q,
  input  logic              csr_q,
  input  logic              pol_q,
  input  logic [MISC_W-1:0] misc_q,
  input  logic [TEST_W-1:0] test_q,
  output logic [WORD_W-1:0] word
);
  if (ADDR_W + FMSB_W + N_W > WORD_W) begin : g_main_too_wide
    $error("main word fields exceed word width");
  end
  if (ADDR_W + RDIV_W + 2 > CSR_BIT) begin : g_ref_overlap
    $error("reference fields overlap the slip-reduction bit");
  end

  function automatic logic [WORD_W-1:0] pack_main(input logic [N_W-1:0] n,
                                                  input logic [FMSB_W-1:0] hi);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ADDR_W-1:0]               = SEL_MAIN;
    w[ADDR_W +: FMSB_W]         = hi;
    w[ADDR_W + FMSB_W +: N_W]   = n;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_flo(input logic [FLSB_W-1:0] lo);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ADDR_W-1:0]       = SEL_FLO;
    w[ADDR_W +: FLSB_W] = lo;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_ref(input logic [RDIV_W-1:0] r,
                                                 input logic h, input logic d,
                                                 input logic slip);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ADDR_W-1:0]           = SEL_REF;
    w[ADDR_W +: RDIV_W]     = r;
    w[ADDR_W + RDIV_W]      = h;
    w[ADDR_W + RDIV_W + 1]  = d;
    w[CSR_BIT]              = slip;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_func(input logic [MISC_W-1:0] m,
                                                  input logic pol);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ADDR_W-1:0]           = SEL_FUNC;
    w[POL_BIT]              = pol;
    w[POL_BIT + 1 +: MISC_W] = m;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_test(input logic [TEST_W-1:0] t);
    return {t, SEL_TEST};
  endfunction

  logic [FMSB_W-1:0] frac_hi;
  logic [FLSB_W-1:0] frac_lo;
  logic              slip_ok;

  assign frac_hi = frac_q[FRAC_W-1:FLSB_W];
  assign frac_lo = frac_q[FLSB_W-1:0];
  assign slip_ok = csr_q && pol_q;

  always_comb begin
    case (step)
      SEL_MAIN: word = pack_main(n_q, frac_hi);
      SEL_FLO:  word = pack_flo(frac_lo);
      SEL_REF:  word = pack_ref(rdiv_q, half_q, dbl_q, slip_ok);
      SEL_FUNC: word = pack_func(misc_q, pol_q);
      SEL_TEST: word = pack_test(test_q);
      default:  word = '0;
    endcase
  end
endmodule

// File: rtl/synth_load_seq.sv
module synth_load_seq
  import synth_seq_pkg::*;
#(
  parameter int N_W    = 16,
  parameter int FMSB_W = 12,
  parameter int FLSB_W = 13,
  parameter int RDIV_W = 5,
  localparam int FRAC_W = FMSB_W + FLSB_W,
  localparam int MISC_W = WORD_W - POL_BIT - 1,
  localparam int TEST_W = WORD_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              retune,
  input  logic [N_W-1:0]    n_int,
  input  logic [FRAC_W-1:0] frac,
  input  logic [RDIV_W-1:0] r_div,
  input  logic              ref_half,
  input  logic              ref_dbl,
  input  logic              csr_en,
  input  logic              pd_pos,
  input  logic [MISC_W-1:0] func_misc,
  input  logic [TEST_W-1:0] test_val,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [WORD_W-1:0] wr_data,
  output logic              busy,
  output logic              done
);
  logic              fire;
  logic              go_full;
  logic              go_frac;
  logic              accept_last;
  logic              busy_w;
  logic [ADDR_W-1:0] step;

  logic [N_W-1:0]    n_q;
  logic [FRAC_W-1:0] frac_q;
  logic [RDIV_W-1:0] rdiv_q;
  logic              half_q, dbl_q, csr_q, pol_q;
  logic [MISC_W-1:0] misc_q;
  logic [TEST_W-1:0] test_q;

  assign fire = busy_w && wr_ready;

  seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .retune(retune), .fire(fire),
    .busy(busy_w), .done(done), .step(step), .go_full(go_full),
    .go_frac(go_frac), .accept_last(accept_last)
  );

  cfg_hold #(
    .N_W(N_W), .FRAC_W(FRAC_W), .RDIV_W(RDIV_W), .MISC_W(MISC_W), .TEST_W(TEST_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cap_all(go_full), .cap_frac(go_frac),
    .n_in(n_int), .frac_in(frac), .rdiv_in(r_div), .half_in(ref_half),
    .dbl_in(ref_dbl), .csr_in(csr_en), .pol_in(pd_pos), .misc_in(func_misc),
    .test_in(test_val),
    .n_q(n_q), .frac_q(frac_q), .rdiv_q(rdiv_q), .half_q(half_q), .dbl_q(dbl_q),
    .csr_q(csr_q), .pol_q(pol_q), .misc_q(misc_q), .test_q(test_q)
  );

  word_mux #(
    .N_W(N_W), .FMSB_W(FMSB_W), .FLSB_W(FLSB_W), .RDIV_W(RDIV_W)
  ) u_mux (
    .step(step), .n_q(n_q), .frac_q(frac_q), .rdiv_q(rdiv_q), .half_q(half_q),
    .dbl_q(dbl_q), .csr_q(csr_q), .pol_q(pol_q), .misc_q(misc_q),
    .test_q(test_q), .word(wr_data)
  );

  assign wr_valid = busy_w;
  assign busy     = busy_w;

  // R4
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data));
  // R7
  csr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_data[ADDR_W-1:0] == SEL_REF && !pol_q |-> !wr_data[CSR_BIT]);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> !wr_valid);
endmodule

// File: tb/synth_load_seq_test.sv
module synth_load_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, retune = 1'b0;
  logic [15:0] n_int = '0;
  logic [24:0] frac = '0;
  logic [4:0]  r_div = '0;
  logic        ref_half = 1'b0, ref_dbl = 1'b0, csr_en = 1'b0, pd_pos = 1'b1;
  logic [24:0] func_misc = '0;
  logic [28:0] test_val = '0;
  logic        wr_valid, wr_ready, busy, done;
  logic [31:0] wr_data;

  int n_checks = 0, n_fail = 0;
  bit stall_mode = 1'b0, mon_on = 1'b0, finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  synth_load_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .retune(retune), .n_int(n_int),
    .frac(frac), .r_div(r_div), .ref_half(ref_half), .ref_dbl(ref_dbl),
    .csr_en(csr_en), .pd_pos(pd_pos), .func_misc(func_misc),
    .test_val(test_val), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] w_main(input int n, input int f);
    return 32'(longint'(n) * 32768 + (f / 8192) * 8);
  endfunction
  function automatic logic [31:0] w_flo(input int f);
    return 32'((f % 8192) * 8 + 1);
  endfunction
  function automatic logic [31:0] w_ref(input int r, input int h, input int d, input int c, input int p);
    return 32'(longint'(r) * 8 + h * 256 + d * 512 + ((c != 0 && p != 0) ? 268435456 : 0) + 2);
  endfunction
  function automatic logic [31:0] w_func(input int m, input int p);
    return 32'(longint'(m) * 128 + p * 64 + 3);
  endfunction
  function automatic logic [31:0] w_test(input int t);
    return 32'(longint'(t) * 8 + 4);
  endfunction

  task automatic push(input logic [31:0] w, input string tg);
    exp_q.push_back(w);
    tag_q.push_back(tg);
  endtask

  task automatic push_frac(input string tg);
    push(w_flo(int'(frac)), {tg, "/R6"});
    push(w_main(int'(n_int), int'(frac)), {tg, "/R5"});
  endtask

  task automatic push_full(input string tg);
    push(w_test(int'(test_val)), {tg, "/R8"});
    push(w_func(int'(func_misc), int'(pd_pos)), {tg, "/R8"});
    push(w_ref(int'(r_div), int'(ref_half), int'(ref_dbl), int'(csr_en), int'(pd_pos)), {tg, "/R7"});
    push_frac(tg);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  // driver: pushes expected words, then pulses the request
  task automatic launch(input bit full, input bit frc, input string tg);
    @(negedge clk);
    if (full) push_full(tg); else push_frac(tg);
    start = full;
    retune = frc;
    @(negedge clk);
    start = 1'b0;
    retune = 1'b0;
    check(busy === 1'b1, tg, busy, 1);
    wait_idle();
  endtask

  // monitor: drives ready, pops and compares accepted words
  bit          pv = 0, pr = 0, plast = 0;
  logic [31:0] pd = '0;
  always @(negedge clk) begin
    logic r;
    if (mon_on) begin
      if (pv && !pr) begin
        check(wr_valid === 1'b1, "R4 valid held", wr_valid, 1);
        check(wr_data === pd, "R4 data held", wr_data, pd);
      end
      if (plast) begin
        check(done === 1'b1, "R10 done pulse", done, 1);
        check(busy === 1'b0, "R10 busy falls", busy, 0);
      end else begin
        check(done === 1'b0, "R10 done quiet", done, 0);
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = stall_mode ? lfsr[0] : 1'b1;
      wr_ready = r;
      if (wr_valid && r) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected write", wr_data, 0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(wr_data === e, {t, " R2 word"}, wr_data, e);
        end
      end
      pv = wr_valid;
      pr = r;
      pd = wr_data;
      plast = wr_valid && r && (wr_data[2:0] == 3'd0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    wr_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R1 busy", busy, 0);
    check(wr_valid === 1'b0, "R1 valid", wr_valid, 0);
    check(done === 1'b0, "R1 done", done, 0);
    mon_on = 1'b1;

    // R2 / R5 / R6: worked example N=580, upper 81, lower 7537
    n_int = 16'd580; frac = 25'(81 * 8192 + 7537);
    r_div = 5'd1; pd_pos = 1'b1; csr_en = 1'b1;
    func_misc = 25'h0ABCDE; test_val = 29'h0000123;
    launch(1'b1, 1'b0, "R2 example");

    // R4: stalls on the write port with other values
    stall_mode = 1'b1;
    n_int = 16'hFFFF; frac = 25'h1FFFFFF; r_div = 5'h1F;
    ref_half = 1'b1; ref_dbl = 1'b1; func_misc = 25'h1FFFFFF; test_val = 29'h1FFFFFFF;
    launch(1'b1, 1'b0, "R4 stall");

    // R3: fraction-only update
    n_int = 16'd581; frac = 25'd12345;
    launch(1'b0, 1'b1, "R3 retune");

    // R9: request and input change during a running load
    @(negedge clk);
    n_int = 16'd100; frac = 25'd99999; r_div = 5'd3; pd_pos = 1'b1; csr_en = 1'b0;
    push_full("R9 busy");
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    n_int = 16'd7; frac = 25'd1; r_div = 5'd9; func_misc = 25'd5; test_val = 29'd6;
    start = 1'b1; retune = 1'b1;
    @(negedge clk);
    start = 1'b0; retune = 1'b0;
    wait_idle();

    // R7: slip reduction masked by negative polarity
    stall_mode = 1'b0;
    csr_en = 1'b1; pd_pos = 1'b0;
    launch(1'b1, 1'b0, "R7 pol neg");

    // R11: start and retune together
    pd_pos = 1'b1; frac = 25'd4242;
    launch(1'b1, 1'b1, "R11 both");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all writes seen", exp_q.size(), 0);
    check(busy === 1'b0, "R9 idle at end", busy, 0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule